// File: doc/BRIEF.md
# Modem Handshake Control and Status Unit

This unit is the modem-handshake slice of a 16550-class serial port. A control register set by the CPU drives four active-low handshake outputs (data-terminal-ready, request-to-send and two general-purpose outputs) and selects an internal loopback mode. A status register reports the present level of the four active-low handshake inputs (clear-to-send, data-set-ready, ring indicator and carrier detect). It also latches a change flag for each of these inputs. A modem-status interrupt request is raised when a qualifying change occurs.

The external inputs are brought into the clock domain by a two-stage synchronizer before any edge is detected. Reading the status register returns the flags and clears them. A change that lands on the same clock edge as that read is still recorded. In loopback mode the control bits feed the status inputs internally and every handshake output is held inactive. While automatic clear-to-send flow control is on, a clear-to-send change still sets its flag but does not request an interrupt.

Two state machines shape the behaviour:

- **Mode register.** Its states are `MODE_NORMAL` and `MODE_LOOP`.
  - `enter_loop`: a control write with bit 4 set.
  - `leave_loop`: a control write with bit 4 clear.
- **Interrupt tracker.** Its states are `ST_IDLE` and `ST_PEND`.
  - `raise`: any interrupt-eligible change.
  - `service`: a status read with no eligible change on the same edge.
  - `hold`: a status read together with an eligible change, which stays in `ST_PEND`.

Top module: `modem_ctl_top`

## Requirements
- R1: After reset the control register reads 0x00. All four handshake outputs are high, the interrupt output is low, and with all inputs held high the status register reads 0x00.
- R2: Control register bit 0 drives dtr_n, bit 1 drives rts_n, bit 2 drives out1_n and bit 3 drives out2_n. A set bit drives its pin low. Bit 4 is the loopback enable. A read returns bits 4:0 as written and returns bits 7:5 as zero.
- R3: Status bits 4, 5, 6 and 7 report the complement of cts_n, dsr_n, ri_n and dcd_n respectively.
- R4: Status bits 0, 1 and 3 set on any level change of clear-to-send, data-set-ready and carrier-detect respectively. Status bit 2 sets only when the ring indicator goes from active to inactive, and never on its leading edge.
- R5: A status read (reg_rd with reg_sel=1) returns the flags and clears bits 3:0 on that clock edge. A flag whose change arrives on that same edge is set afterwards.
- R6: A change that sets status bit 0, 1, 2 or 3 makes an interrupt pending. The msi_irq output is high while the request is pending and msi_en is high. A status read clears the pending request unless a new eligible change arrives on the same edge.
- R7: While auto_cts_en is high, a clear-to-send change sets status bit 0 but does not make an interrupt pending.
- R8: While loopback is enabled, dtr_n, rts_n, out1_n and out2_n are all high whatever bits 3:0 hold.
- R9: In loopback, bit 0 (DTR) feeds the data-set-ready status, bit 1 (RTS) feeds clear-to-send, bit 2 feeds ring indicator and bit 3 feeds carrier-detect. The external input pins have no effect.
- R10: An external input change shows in the status level bits after two clock edges. Its flag and any interrupt follow on the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| reg_wr | input | 1 | Write strobe; only the control register is writable |
| reg_rd | input | 1 | Read strobe; a status read clears the change flags |
| reg_sel | input | 1 | Register select: 0 for control, 1 for status |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the selected register (combinational) |
| cts_n | input | 1 | Clear-to-send input, active low |
| dsr_n | input | 1 | Data-set-ready input, active low |
| ri_n | input | 1 | Ring-indicator input, active low |
| dcd_n | input | 1 | Carrier-detect input, active low |
| dtr_n | output | 1 | Data-terminal-ready output, active low |
| rts_n | output | 1 | Request-to-send output, active low |
| out1_n | output | 1 | General-purpose output 1, active low |
| out2_n | output | 1 | General-purpose output 2, active low |
| auto_cts_en | input | 1 | Automatic clear-to-send flow control is on |
| msi_en | input | 1 | Modem-status interrupt enable |
| msi_irq | output | 1 | Modem-status interrupt request, active high |

## Verification
A flag register that drops a change or clears out of turn shows on the very next status read as a wrong low nibble. It also shows within one edge as msi_irq failing to rise, or failing to fall after service.

A bad loopback source mapping or a stuck mode state gives wrong level bits on the first status read after the control write. A missing output override shows on the pins as soon as the write edge has passed.

The read that collides with a carrier-detect change is timed to the exact edge. This exposes a clear that wins over a set, which would lose the flag for good.

// File: rtl/modem_pkg.sv
`timescale 1ns/1ps
package modem_pkg;
    // number of handshake lines on each side
    localparam int LINES = 4;
    localparam int REG_W = 8;

    // status-side line index: also the flag bit, and level bit = index + LINES
    localparam int LN_CTS = 0;
    localparam int LN_DSR = 1;
    localparam int LN_RI  = 2;
    localparam int LN_DCD = 3;

    // control register bit positions
    localparam int MC_DTR  = 0;
    localparam int MC_RTS  = 1;
    localparam int MC_OUT1 = 2;
    localparam int MC_OUT2 = 3;
    localparam int MC_LOOP = 4;
    localparam int MC_W    = MC_LOOP + 1;

    typedef enum logic {
        SEL_CTL = 1'b0,
        SEL_STAT = 1'b1
    } reg_sel_e;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_LOOP = 1'b1
    } mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } irq_st_e;
endpackage

// File: rtl/modem_sync.sv
`timescale 1ns/1ps
module modem_sync #(
    parameter int W = 4,
    parameter int STAGES = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int LAST = STAGES - 1;

    for (genvar g = 0; g < W; g++) begin : g_line
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RST_VAL}};
            end else begin
                chain_q <= {chain_q[STAGES-2:0], din[g]};
            end
        end

        assign dout[g] = chain_q[LAST];
    end
endmodule

// File: rtl/modem_mcr.sv
`timescale 1ns/1ps
module modem_mcr
    import modem_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [MC_W-1:0]  wr_data,
    output logic [LINES-1:0] ctl_q,
    output logic             loop_on,
    output logic [LINES-1:0] pins_n
);
    mode_e mode_q, mode_nxt;

    // handshake output bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_en) begin
            ctl_q <= wr_data[LINES-1:0];
        end
    end

    // mode state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_NORMAL;
        end else begin
            mode_q <= mode_nxt;
        end
    end

    // mode transitions: enter_loop / leave_loop
    always_comb begin
        mode_nxt = mode_q;
        unique case (mode_q)
            MODE_NORMAL: if (wr_en && wr_data[MC_LOOP]) mode_nxt = MODE_LOOP;
            MODE_LOOP:   if (wr_en && !wr_data[MC_LOOP]) mode_nxt = MODE_NORMAL;
        endcase
    end

    // outputs per state
    always_comb begin
        unique case (mode_q)
            MODE_NORMAL: begin
                loop_on = 1'b0;
                pins_n  = ~ctl_q;
            end
            MODE_LOOP: begin
                loop_on = 1'b1;
                pins_n  = '1;
            end
        endcase
    end

    AST_LOOP_PINS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[MC_LOOP]) |=> (pins_n == '1)); // R8

    AST_WRITE_DRIVES_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[MC_LOOP]) |=> (pins_n == ~$past(wr_data[LINES-1:0]))); // R2
endmodule

// File: rtl/modem_msr.sv
`timescale 1ns/1ps
module modem_msr
    import modem_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] ext_lvl,
    input  logic             loop_on,
    input  logic [LINES-1:0] ctl_q,
    input  logic             rd_clr,
    output logic [REG_W-1:0] msr,
    output logic [LINES-1:0] set_vec
);
    logic [LINES-1:0] lvl_now;
    logic [LINES-1:0] lvl_q;
    logic [LINES-1:0] delta_q;

    // level source: internal loop or synchronized pins
    always_comb begin
        if (loop_on) begin
            lvl_now[LN_CTS] = ctl_q[MC_RTS];
            lvl_now[LN_DSR] = ctl_q[MC_DTR];
            lvl_now[LN_RI]  = ctl_q[MC_OUT1];
            lvl_now[LN_DCD] = ctl_q[MC_OUT2];
        end else begin
            lvl_now = ext_lvl;
        end
    end

    // change detection; ring indicator only on its trailing edge
    always_comb begin
        set_vec = lvl_now ^ lvl_q;
        set_vec[LN_RI] = lvl_q[LN_RI] & ~lvl_now[LN_RI];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q   <= '0;
            delta_q <= '0;
        end else begin
            lvl_q   <= lvl_now;
            delta_q <= (rd_clr ? '0 : delta_q) | set_vec;
        end
    end

    assign msr = {lvl_now, delta_q};

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((delta_q & $past(set_vec)) == $past(set_vec))); // R5

    AST_READ_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && set_vec == '0) |=> (delta_q == '0)); // R5

    AST_RI_LEAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !lvl_q[LN_RI]) |=> !delta_q[LN_RI]); // R4
endmodule

// File: rtl/modem_irq_fsm.sv
`timescale 1ns/1ps
module modem_irq_fsm
    import modem_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] set_vec,
    input  logic             auto_cts,
    input  logic             msi_en,
    input  logic             rd_clr,
    output logic             irq
);
    irq_st_e st_q, st_nxt;
    logic [LINES-1:0] elig_mask;
    logic evt;

    // clear-to-send excluded from requests in flow-control mode
    always_comb begin
        elig_mask = '1;
        elig_mask[LN_CTS] = ~auto_cts;
        evt = |(set_vec & elig_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nxt;
        end
    end

    // raise / service / hold
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE: if (evt) st_nxt = ST_PEND;
            ST_PEND: if (rd_clr && !evt) st_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (st_q)
            ST_IDLE: irq = 1'b0;
            ST_PEND: irq = msi_en;
        endcase
    end

    AST_SERVICE_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !evt) |=> !irq); // R6

    AST_EVENT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && msi_en) |=> (st_q == ST_PEND)); // R6

    AST_AUTOCTS_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && auto_cts && set_vec == 4'b0001) |=> (st_q == ST_IDLE)); // R7
endmodule

// File: rtl/modem_ctl_top.sv
`timescale 1ns/1ps
module modem_ctl_top
    import modem_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic       reg_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       cts_n,
    input  logic       dsr_n,
    input  logic       ri_n,
    input  logic       dcd_n,
    output logic       dtr_n,
    output logic       rts_n,
    output logic       out1_n,
    output logic       out2_n,
    input  logic       auto_cts_en,
    input  logic       msi_en,
    output logic       msi_irq
);
    logic [LINES-1:0] pins_in_n;
    logic [LINES-1:0] pins_sync_n;
    logic [LINES-1:0] ctl_q;
    logic [LINES-1:0] pins_out_n;
    logic [LINES-1:0] set_vec;
    logic [REG_W-1:0] msr;
    logic             loop_on;
    logic             ctl_wr;
    logic             rd_clr;
    logic             unused_wr_hi;

    assign unused_wr_hi = ^wr_data[REG_W-1:MC_W];

    assign pins_in_n[LN_CTS] = cts_n;
    assign pins_in_n[LN_DSR] = dsr_n;
    assign pins_in_n[LN_RI]  = ri_n;
    assign pins_in_n[LN_DCD] = dcd_n;

    assign ctl_wr = reg_wr && (reg_sel == SEL_CTL);
    assign rd_clr = reg_rd && (reg_sel == SEL_STAT);

    modem_sync #(.W(LINES), .STAGES(2), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pins_in_n),
        .dout  (pins_sync_n)
    );

    modem_mcr u_mcr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_wr),
        .wr_data (wr_data[MC_W-1:0]),
        .ctl_q   (ctl_q),
        .loop_on (loop_on),
        .pins_n  (pins_out_n)
    );

    modem_msr u_msr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_lvl (~pins_sync_n),
        .loop_on (loop_on),
        .ctl_q   (ctl_q),
        .rd_clr  (rd_clr),
        .msr     (msr),
        .set_vec (set_vec)
    );

    modem_irq_fsm u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .auto_cts (auto_cts_en),
        .msi_en   (msi_en),
        .rd_clr   (rd_clr),
        .irq      (msi_irq)
    );

    assign dtr_n  = pins_out_n[MC_DTR];
    assign rts_n  = pins_out_n[MC_RTS];
    assign out1_n = pins_out_n[MC_OUT1];
    assign out2_n = pins_out_n[MC_OUT2];

    always_comb begin
        unique case (reg_sel_e'(reg_sel))
            SEL_CTL:  rd_data = {{(REG_W-MC_W){1'b0}}, loop_on, ctl_q};
            SEL_STAT: rd_data = msr;
        endcase
    end

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !msi_en |-> !msi_irq); // R6

    AST_LOOP_IGNORES_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_on && $past(loop_on) && $stable(ctl_q)) |-> (set_vec == '0)); // R9
endmodule

// File: tb/sim_modem_ctl_top.sv
`timescale 1ns/1ps
module sim_modem_ctl_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       cts_n = 1'b1;
    logic       dsr_n = 1'b1;
    logic       ri_n = 1'b1;
    logic       dcd_n = 1'b1;
    logic       dtr_n, rts_n, out1_n, out2_n;
    logic       auto_cts_en = 1'b0;
    logic       msi_en = 1'b1;
    logic       msi_irq;

    typedef struct {
        int         kind;   // 0 read data, 1 pins {dtr,rts,out1,out2}, 2 irq
        logic [7:0] val;
        string      req;
    } exp_t;

    exp_t sb_q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    modem_ctl_top u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .wr_data(wr_data), .rd_data(rd_data),
        .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
        .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n),
        .auto_cts_en(auto_cts_en), .msi_en(msi_en), .msi_irq(msi_irq)
    );

    // monitor: compares queued expectations mid-cycle
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_t e;
            logic [7:0] act;
            e = sb_q.pop_front();
            case (e.kind)
                0: act = rd_data;
                1: act = {4'h0, dtr_n, rts_n, out1_n, out2_n};
                default: act = {7'h0, msi_irq};
            endcase
            n_vec++;
            if (act !== e.val) begin
                n_bad++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", e.req, e.kind, act, e.val);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic push(input int kind, input logic [7:0] val, input string req);
        exp_t e;
        e.kind = kind; e.val = val; e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic exp_pins(input logic [3:0] v, input string req);
        push(1, {4'h0, v}, req);
    endtask

    task automatic exp_irq(input logic v, input string req);
        push(2, {7'h0, v}, req);
    endtask

    task automatic rd_reg(input logic sel, input logic [7:0] v, input string req);
        reg_sel = sel;
        reg_rd = 1'b1;
        push(0, v, req);
        tick(1);
        reg_rd = 1'b0;
    endtask

    task automatic wr_ctl(input logic [7:0] d);
        reg_sel = 1'b0;
        wr_data = d;
        reg_wr = 1'b1;
        tick(1);
        reg_wr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R1..all actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        tick(2);
        rst_n = 1'b1;
        tick(3);
        // R1 reset state
        exp_pins(4'b1111, "R1 pins");
        exp_irq(1'b0, "R1 irq");
        rd_reg(1'b0, 8'h00, "R1 ctl");
        rd_reg(1'b1, 8'h00, "R1 stat");

        // R2 control bits to pins
        wr_ctl(8'h0F);
        exp_pins(4'b0000, "R2 all set");
        wr_ctl(8'h05);
        exp_pins(4'b0101, "R2 dtr+out1");
        rd_reg(1'b0, 8'h05, "R2 readback");
        wr_ctl(8'hE3);
        exp_pins(4'b0011, "R2 dtr+rts");
        rd_reg(1'b0, 8'h03, "R2 upper zero");

        // R3/R4/R10 data-set-ready change
        dsr_n = 1'b0;
        tick(2);
        rd_reg(1'b1, 8'h20, "R10 level after two edges");
        exp_irq(1'b1, "R6 dsr irq");
        rd_reg(1'b1, 8'h22, "R4 dsr flag");
        exp_irq(1'b0, "R6 serviced");
        rd_reg(1'b1, 8'h20, "R5 cleared");

        // carrier detect
        dcd_n = 1'b0;
        tick(3);
        exp_irq(1'b1, "R6 dcd irq");
        rd_reg(1'b1, 8'hA8, "R4 dcd flag");

        // clear-to-send, auto off
        cts_n = 1'b0;
        tick(3);
        exp_irq(1'b1, "R6 cts irq");
        rd_reg(1'b1, 8'hB1, "R3 cts level flag");
        exp_irq(1'b0, "R6 serviced");

        // R7 auto-cts masks the request
        auto_cts_en = 1'b1;
        cts_n = 1'b1;
        tick(3);
        exp_irq(1'b0, "R7 no irq");
        rd_reg(1'b1, 8'hA1, "R7 flag still set");
        auto_cts_en = 1'b0;

        // R4 ring indicator: leading edge no flag, trailing edge flag
        ri_n = 1'b0;
        tick(3);
        exp_irq(1'b0, "R4 ri leading no irq");
        rd_reg(1'b1, 8'hE0, "R4 ri leading");
        ri_n = 1'b1;
        tick(3);
        exp_irq(1'b1, "R4 ri trailing irq");
        rd_reg(1'b1, 8'hA4, "R4 ri trailing flag");
        exp_irq(1'b0, "R6 serviced");

        // R6 enable gates the output, not the pending state
        msi_en = 1'b0;
        dsr_n = 1'b1;
        tick(3);
        exp_irq(1'b0, "R6 disabled");
        tick(1);
        msi_en = 1'b1;
        exp_irq(1'b1, "R6 pending shows on enable");
        rd_reg(1'b1, 8'h82, "R4 dsr fall flag");
        exp_irq(1'b0, "R6 serviced");

        // R5 read on the same edge as a change
        dcd_n = 1'b1;
        tick(2);
        rd_reg(1'b1, 8'h00, "R5 collision read");
        exp_irq(1'b1, "R6 event on read edge");
        rd_reg(1'b1, 8'h08, "R5 flag kept");
        exp_irq(1'b0, "R6 serviced");

        // R8/R9 loopback
        wr_ctl(8'h1F);
        exp_pins(4'b1111, "R8 loop pins high");
        tick(1);
        exp_irq(1'b1, "R9 loop irq");
        rd_reg(1'b1, 8'hFB, "R9 loop map set");
        rd_reg(1'b0, 8'h1F, "R2 loop readback");
        wr_ctl(8'h10);
        tick(1);
        rd_reg(1'b1, 8'h0F, "R9 loop map clear");
        dsr_n = 1'b0;
        tick(3);
        exp_pins(4'b1111, "R8 loop pins high");
        rd_reg(1'b1, 8'h00, "R9 pins ignored");
        wr_ctl(8'h00);
        tick(1);
        rd_reg(1'b1, 8'h22, "R9 external again");

        // R1 reset mid-operation
        dsr_n = 1'b1;
        tick(3);
        wr_ctl(8'h0F);
        exp_pins(4'b0000, "R2 before reset");
        tick(1);
        rst_n = 1'b0;
        exp_pins(4'b1111, "R1 reset pins");
        exp_irq(1'b0, "R1 reset irq");
        tick(1);
        rst_n = 1'b1;
        tick(3);
        rd_reg(1'b0, 8'h00, "R1 ctl after reset");
        rd_reg(1'b1, 8'h00, "R1 stat after reset");

        tick(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule